// File: doc/BRIEF.md
# Software-Triggered Bus Reset Pulser

This block drives the active-low reset line of a peripheral bus. Software can reset that bus without resetting the processor side. An 8-bit control register, reached through a simple write/read port, holds one active bit. When a write takes that bit from 0 to 1, the block holds the bus reset low for a fixed minimum time. That time is derived from a clock-frequency parameter and a duration parameter given in microseconds. The bus reset is also held low whenever the host hard or power-on reset is asserted, and it is released at the same moment as the host reset.

Two pieces of logic do the work. The register stage holds the control bit and produces a one-cycle trigger when a write raises it. The timer is a two-state machine:

- **ST_IDLE**: the bus reset is not driven and busy is low.
- **ST_PULSE**: the bus reset is driven low and busy is high, while a down-counter runs.

The machine has three transitions:

- **T_START** (ST_IDLE to ST_PULSE): taken on a trigger while idle. The counter is loaded with the pulse length minus one.
- **T_HOLD** (ST_PULSE to ST_PULSE): taken while the counter is above zero. The counter decrements.
- **T_EXPIRE** (ST_PULSE to ST_IDLE): taken when the counter reaches zero.

The host reset returns the machine to ST_IDLE from either state and clears the control bit.

Top module: `bus_reset_pulser`

## Requirements
- R1: While `host_rst_n` is low, `bus_rst_n` is 0, `busy` is 0 and `reg_rd_data` reads 0x00. After release with no write, `bus_rst_n` is 1.
- R2: A write stores `reg_wr_data[0]` as control bit 0, which reads back on `reg_rd_data[0]` and keeps its value until the next write. Bits 7:1 ignore written values and always read 0. A write that leaves bit 0 at 0 starts no pulse.
- R3: A write on clock edge k that takes bit 0 from 0 to 1 drives `bus_rst_n` low and `busy` high from edge k through edge k+N, where N is the pulse length of R8. Both are therefore active for exactly N clock cycles.
- R4: Writing 1 while bit 0 is already 1 starts no pulse, and `bus_rst_n` stays 1.
- R5: During an active pulse, a write of 0 followed by a write of 1 neither extends nor restarts the pulse. The pulse still ends N cycles after its start, and bit 0 then reads 1.
- R6: A 0-to-1 write taken on the edge where the pulse expires (edge k+N) is ignored, and no new pulse follows. Once the block is idle, a later 0-to-1 write starts a full N-cycle pulse.
- R7: Asserting `host_rst_n` low drives `bus_rst_n` low at once, without waiting for a clock edge. It aborts any pulse (`busy` 0) and clears bit 0. Releasing `host_rst_n` releases `bus_rst_n` in the same instant.
- R8: N = ceil(CLK_FREQ_HZ * PULSE_US / 1,000,000), with a minimum of 1. The bench uses CLK_FREQ_HZ = 40,000 and PULSE_US = 999, which gives N = 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| host_rst_n | input | 1 | Host hard / power-on reset, active low, asynchronous |
| reg_wr_en | input | 1 | Register write strobe, sampled on the rising clock edge |
| reg_wr_data | input | 8 | Write data; only bit 0 is stored |
| reg_rd_data | output | 8 | Register read value, bit 0 = control bit, bits 7:1 = 0 |
| bus_rst_n | output | 1 | Bus reset, active low |
| busy | output | 1 | High while the pulse counter runs |

## Verification
The sharpest collision is a fresh 0-to-1 write that lands on the very edge where the timer expires. At that edge the trigger and T_EXPIRE happen together, and the trigger must lose. The bench provokes this by writing 0 and then 1 so that the second write is taken exactly N edges after the pulse began. It then checks that `bus_rst_n` is high and `busy` is low on the following cycle. A second collision asserts the host reset in the middle of a pulse. Here the bus line must stay low, the counter must abort, and the line must rise in the same instant the host reset is released.

// File: rtl/bus_rst_pkg.sv
package bus_rst_pkg;

    localparam int unsigned CTRL_W = 8;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } pulse_state_e;

    // Pulse length in clock cycles: ceil(freq * us / 1e6), never below 1.
    function automatic longint unsigned pulse_cycles(
        input longint unsigned freq_hz,
        input longint unsigned dur_us
    );
        longint unsigned prod;
        longint unsigned cyc;
        prod = freq_hz * dur_us;
        cyc  = (prod + 64'd999_999) / 64'd1_000_000;
        if (cyc == 64'd0) cyc = 64'd1;
        return cyc;
    endfunction

endpackage

// File: rtl/bus_rst_ctrl.sv
module bus_rst_ctrl #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    output logic             trig
);

    localparam int unsigned RSV_W = WIDTH - 1;

    logic arm_q;

    // Control bit keeps its written value until the next write.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_q <= 1'b0;
        end else if (wr_en) begin
            arm_q <= wr_data[0];
        end
    end

    // One-cycle trigger on a write that raises the bit.
    always_comb begin
        trig = wr_en & wr_data[0] & ~arm_q;
    end

    assign rd_data = {{RSV_W{1'b0}}, arm_q};

    // R2: the bit only changes on a write
    assert_bit_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(rd_data))
        else $error("control bit changed without a write");

endmodule

// File: rtl/bus_rst_timer.sv
module bus_rst_timer
    import bus_rst_pkg::*;
#(
    parameter int unsigned CYCLES = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic drive
);

    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

    pulse_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_PULSE;           // T_START
            ST_PULSE: if (cnt_q == '0) state_d = ST_IDLE;      // T_EXPIRE, else T_HOLD
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Down-counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (start) cnt_q <= LOAD;
                ST_PULSE: if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
                default:  cnt_q <= '0;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        busy  = 1'b0;
        drive = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin busy = 1'b0; drive = 1'b0; end
            ST_PULSE: begin busy = 1'b1; drive = 1'b1; end
            default:  begin busy = 1'b0; drive = 1'b0; end
        endcase
    end

    // Checker: measure each pulse length.
    logic [CW:0] chk_len;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_len <= '0;
        end else if (state_q == ST_IDLE && state_d == ST_PULSE) begin
            chk_len <= (CW+1)'(1);
        end else if (state_q == ST_PULSE && state_d == ST_PULSE) begin
            chk_len <= chk_len + (CW+1)'(1);
        end
    end

    // R3: every completed pulse lasts exactly CYCLES cycles
    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (chk_len == (CW+1)'(CYCLES)))
        else $error("pulse length %0d, expected %0d", chk_len, CYCLES);

    // R5: counter never leaves its loaded range while running
    assert_cnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q <= LOAD))
        else $error("pulse counter out of range");

endmodule

// File: rtl/bus_reset_pulser.sv
module bus_reset_pulser
    import bus_rst_pkg::*;
#(
    parameter int unsigned CLK_FREQ_HZ = 100_000_000,
    parameter int unsigned PULSE_US    = 1000
) (
    input  logic              clk,
    input  logic              host_rst_n,
    input  logic              reg_wr_en,
    input  logic [CTRL_W-1:0] reg_wr_data,
    output logic [CTRL_W-1:0] reg_rd_data,
    output logic              bus_rst_n,
    output logic              busy
);

    localparam longint unsigned CYC64 =
        pulse_cycles(longint'(CLK_FREQ_HZ), longint'(PULSE_US));
    localparam int unsigned PULSE_CYCLES = int'(CYC64);

    logic trig;
    logic drive;

    bus_rst_ctrl #(.WIDTH(CTRL_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (host_rst_n),
        .wr_en   (reg_wr_en),
        .wr_data (reg_wr_data),
        .rd_data (reg_rd_data),
        .trig    (trig)
    );

    bus_rst_timer #(.CYCLES(PULSE_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (host_rst_n),
        .start (trig),
        .busy  (busy),
        .drive (drive)
    );

    // Host reset and software pulse both pull the line low.
    assign bus_rst_n = host_rst_n & ~drive;

    // R7: host reset forces the bus reset without a clock
    always_comb begin
        if (host_rst_n == 1'b0) begin
            assert_host_forces_R7: assert (bus_rst_n == 1'b0)
                else $error("bus reset not driven during host reset");
        end
    end

    // R3: a raising write while idle starts a pulse on the next cycle
    assert_edge_starts_R3: assert property (@(posedge clk) disable iff (!host_rst_n)
        (trig && !busy) |=> busy)
        else $error("trigger did not start a pulse");

    // R4: a pulse only begins together with a 0-to-1 change of the bit
    assert_start_needs_edge_R4: assert property (@(posedge clk) disable iff (!host_rst_n)
        $rose(busy) |-> (reg_rd_data[0] && !$past(reg_rd_data[0])))
        else $error("pulse started without a rising bit");

endmodule

// File: tb/bus_reset_pulser_bench.sv
module bus_reset_pulser_bench;

    localparam int unsigned FREQ = 40_000;
    localparam int unsigned DUR  = 999;
    // Expected length from R8: ceil(40000*999/1e6) = ceil(39.96) = 40
    localparam int EXP_N = 40;

    logic       clk = 1'b0;
    logic       host_rst_n = 1'b0;
    logic       reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = 8'h00;
    logic [7:0] reg_rd_data;
    logic       bus_rst_n;
    logic       busy;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bus_reset_pulser #(.CLK_FREQ_HZ(FREQ), .PULSE_US(DUR)) u_bus_reset_pulser (
        .clk         (clk),
        .host_rst_n  (host_rst_n),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .bus_rst_n   (bus_rst_n),
        .busy        (busy)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive a write at the current negedge; it is taken on the next edge.
    task automatic wr(input logic [7:0] d);
        reg_wr_en = 1'b1;
        reg_wr_data = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
        reg_wr_data = 8'h00;
    endtask

    // Count consecutive low samples of bus_rst_n starting at this one.
    task automatic count_low(output int n);
        n = 0;
        while (bus_rst_n == 1'b0 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 bus_rst_n in reset", int'(bus_rst_n), 0);
        check("R1 busy in reset", int'(busy), 0);
        check("R1 rd_data in reset", int'(reg_rd_data), 0);
        host_rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 bus_rst_n after release", int'(bus_rst_n), 1);
    endtask

    task automatic t_basic;
        int n;
        wr(8'hFE);
        check("R2 reserved bits read 0", int'(reg_rd_data), 0);
        check("R2 no pulse for bit0=0", int'(busy), 0);
        wr(8'h01);
        check("R3 busy at pulse start", int'(busy), 1);
        check("R2 bit0 reads 1", int'(reg_rd_data), 1);
        count_low(n);
        check("R3 R8 pulse length", n, EXP_N);
        check("R3 busy after pulse", int'(busy), 0);
        check("R2 bit0 holds 1", int'(reg_rd_data), 1);
    endtask

    task automatic t_no_retrig;
        int lows = 0;
        wr(8'hFF);
        for (int i = 0; i < 6; i++) begin
            if (bus_rst_n == 1'b0) lows++;
            @(negedge clk);
        end
        check("R4 no pulse on 1-over-1", lows, 0);
        check("R4 reserved still 0", int'(reg_rd_data), 1);
    endtask

    task automatic t_no_extend;
        int n;
        int lows = 0;
        wr(8'h00);
        wr(8'h01);                 // sample 1 of pulse
        repeat (9) @(negedge clk); // sample 10
        wr(8'h00);                 // sample 11
        wr(8'h01);                 // sample 12
        count_low(n);
        check("R5 remaining length", n, EXP_N - 11);
        check("R5 bit0 reads 1", int'(reg_rd_data), 1);
        for (int i = 0; i < 5; i++) begin
            if (bus_rst_n == 1'b0) lows++;
            @(negedge clk);
        end
        check("R5 no restart after end", lows, 0);
    endtask

    task automatic t_final_edge;
        int n;
        wr(8'h00);
        wr(8'h01);                        // sample 1
        repeat (EXP_N - 2) @(negedge clk); // sample N-1
        wr(8'h00);                        // sample N
        wr(8'h01);                        // taken on expiry edge; sample N+1
        check("R6 bus released after collision", int'(bus_rst_n), 1);
        check("R6 busy low after collision", int'(busy), 0);
        @(negedge clk);
        check("R6 still idle", int'(busy), 0);
        wr(8'h00);
        wr(8'h01);
        count_low(n);
        check("R6 later edge full pulse", n, EXP_N);
    endtask

    task automatic t_host_reset;
        int n;
        wr(8'h00);
        wr(8'h01);
        repeat (5) @(negedge clk);
        #1 host_rst_n = 1'b0;
        #0.5;
        check("R7 bus low in host reset", int'(bus_rst_n), 0);
        check("R7 pulse aborted", int'(busy), 0);
        check("R7 bit0 cleared", int'(reg_rd_data), 0);
        repeat (3) @(negedge clk);
        #1 host_rst_n = 1'b1;
        #0.5;
        check("R7 bus released with host", int'(bus_rst_n), 1);
        @(negedge clk);
        check("R7 idle after host reset", int'(busy), 0);
        wr(8'h01);
        count_low(n);
        check("R7 pulse after host reset", n, EXP_N);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_no_retrig();
        t_no_extend();
        t_final_edge();
        t_host_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #100000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule